// File: doc/BRIEF.md
# Dynamic-Line Retention Sentry

This block decides, for every line held in the dynamic (charge-based) ways of a cache, whether that line's data can still be trusted. Stored charge decays, so a line is only good for a fixed number of cycles after it was written. The block keeps one sentry per dynamic line, separate from the tag valid bit. The sentry records the cycle of the last write. Lines are never refreshed. A line is made fresh again only when a swap writes it back into a dynamic slot, and that write re-arms its sentry.

The cache controller arms a line with its set and way in the cycle the data is written into the dynamic way. It queries a line with its set, way and the result of its own tag comparison. The block returns whether the sentry is still alive, and whether the tag match may count as a hit. A tag match on an expired line must be handled as a miss and fetched from the next level. The sentry window is meant to be set shorter than the true data retention, so an alive answer can always be trusted. Time comes from a free-running cycle counter input that advances by one every clock.

Only the low bits of the counter are stored per line. A background sweeper visits one line per cycle and retires lines whose window has closed. Because of this, a line left untouched for longer than the stored timestamp range can never wrap back to alive.

Top module: `retention_sentry`

## Requirements
- R1: After reset every line, in every set and way, reads not alive until it is armed.
- R2: A line armed when the counter reads T reads alive in the following cycles while the counter value minus T is below RET_CYCLES.
- R3: When an arm and a query for the same line fall in the same cycle, the query returns the state the line had before that arm.
- R4: A line armed at counter value T reads not alive from the cycle in which the counter reaches T + RET_CYCLES. It stays not alive until it is armed again.
- R5: The alive decision is correct when the counter input wraps past its all-ones value while a line is in its window.
- R6: A line left unarmed for far longer than the timestamp range (2^TS_W cycles) still reads not alive and never comes back to life.
- R7: Arming a line that is already alive restarts its window from the new arm cycle.
- R8: qry_hit is 1 only when qry_en is 1, qry_tag_match is 1 and the line is alive. A tag match on an expired line gives qry_hit 0.
- R9: A way number at or above DYN_WAYS is ignored on arm and reads not alive on query.
- R10: Arming one line changes the alive state of no other line.
- R11: With qry_en at 0, qry_alive and qry_hit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_cnt | input | CNT_W | Free-running cycle counter, +1 per clock |
| arm_en | input | 1 | Arm the sentry of a line (data written this cycle) |
| arm_set | input | SET_W | Set of the line to arm |
| arm_way | input | WAY_W | Dynamic way of the line to arm |
| qry_en | input | 1 | Lookup this cycle |
| qry_set | input | SET_W | Set of the queried line |
| qry_way | input | WAY_W | Dynamic way of the queried line |
| qry_tag_match | input | 1 | Controller's tag comparison result for the queried line |
| qry_alive | output | 1 | Queried line's sentry is alive (combinational) |
| qry_hit | output | 1 | Tag match may be used as a hit |

## Verification
The hardest case to reach is a line that sits unarmed long enough for its stored timestamp to wrap. Without the sweeper, such a line would look freshly written again. The bench builds the block with a short window and a few lines, so the timestamp range is only 128 cycles. It then keeps querying one armed line for more than 200 cycles, comparing the result against an absolute-time model that cannot alias. The counter input also starts just below its all-ones value, so counter wraparound falls inside a live window.

// File: rtl/retention_sentry_pkg.sv
package retention_sentry_pkg;

  // Timestamp bits needed so that an expired line is always swept
  // before its age can alias back below the window.
  function automatic int ts_bits(input int ret_cycles, input int entries);
    return $clog2(ret_cycles + entries) + 1;
  endfunction

  // Index bits able to hold the value "entries" itself.
  function automatic int idx_bits(input int entries);
    return $clog2(entries + 1);
  endfunction

  typedef enum logic {
    SWEEP_KEEP = 1'b0,
    SWEEP_DROP = 1'b1
  } sweep_act_e;

endpackage

// File: rtl/rs_age_check.sv
module rs_age_check #(
  parameter int TS_W       = 17,
  parameter int RET_CYCLES = 50000
) (
  input  logic [TS_W-1:0] now_ts,
  input  logic [TS_W-1:0] stamp,
  input  logic            stamp_vld,
  output logic            live
);

  localparam logic [TS_W-1:0] WINDOW = TS_W'(RET_CYCLES);

  logic [TS_W-1:0] age;

  always_comb begin
    age  = now_ts - stamp;
    live = stamp_vld && (age < WINDOW);
  end

endmodule

// File: rtl/rs_sweeper.sv
module rs_sweeper #(
  parameter int ENTRIES = 192,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    if (ptr_q == LAST) ptr_d = '0;
    else               ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R6: the sweep visits only real lines
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

endmodule

// File: rtl/rs_store.sv
module rs_store #(
  parameter int ENTRIES = 192,
  parameter int IDX_W   = 8,
  parameter int TS_W    = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic             rd_a_vld,
  output logic [TS_W-1:0]  rd_a_ts,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_b_vld,
  output logic [TS_W-1:0]  rd_b_ts
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic            vld_q [ENTRIES];
  logic            vld_d [ENTRIES];
  logic [TS_W-1:0] ts_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit_wr;
    logic hit_clr;

    always_comb begin
      hit_wr  = wr_en  && (wr_idx  == IDX_W'(e));
      hit_clr = clr_en && (clr_idx == IDX_W'(e));
      if (hit_wr)       vld_d[e] = 1'b1;
      else if (hit_clr) vld_d[e] = 1'b0;
      else              vld_d[e] = vld_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[e] <= 1'b0;
      else        vld_q[e] <= vld_d[e];
    end

    // Timestamp needs no reset: it is only read while its sentry is set.
    always_ff @(posedge clk) begin
      if (hit_wr) ts_q[e] <= wr_ts;
    end
  end

  always_comb begin
    rd_a_vld = 1'b0;
    rd_a_ts  = '0;
    if (rd_a_idx <= LAST) begin
      rd_a_vld = vld_q[rd_a_idx];
      rd_a_ts  = ts_q[rd_a_idx];
    end
    rd_b_vld = 1'b0;
    rd_b_ts  = '0;
    if (rd_b_idx <= LAST) begin
      rd_b_vld = vld_q[rd_b_idx];
      rd_b_ts  = ts_q[rd_b_idx];
    end
  end

  // R2: an arm leaves its sentry set
  p_arm_marks_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);

  // R6: a sweep drop without a competing arm clears the sentry
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(wr_en && (wr_idx == clr_idx))) |=> !vld_q[$past(clr_idx)]);

endmodule

// File: rtl/retention_sentry.sv
module retention_sentry
  import retention_sentry_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int DYN_WAYS   = 3,
  parameter int RET_CYCLES = 50000,
  parameter int CNT_W      = 32,
  localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W     = (DYN_WAYS > 1) ? $clog2(DYN_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycle_cnt,
  input  logic             arm_en,
  input  logic [SET_W-1:0] arm_set,
  input  logic [WAY_W-1:0] arm_way,
  input  logic             qry_en,
  input  logic [SET_W-1:0] qry_set,
  input  logic [WAY_W-1:0] qry_way,
  input  logic             qry_tag_match,
  output logic             qry_alive,
  output logic             qry_hit
);

  localparam int ENTRIES = SETS * DYN_WAYS;
  localparam int IDX_W   = idx_bits(ENTRIES);
  localparam int TS_W    = ts_bits(RET_CYCLES, ENTRIES);
  localparam logic [WAY_W:0]  WAY_LIM   = (WAY_W + 1)'(DYN_WAYS);
  localparam logic [TS_W-1:0] AGE_BOUND = TS_W'(RET_CYCLES + ENTRIES);

  if (TS_W > CNT_W) begin : g_cnt_too_narrow
    $error("cycle counter narrower than the timestamp it must feed");
  end

  logic [TS_W-1:0]  now_ts;
  logic             arm_ok;
  logic             qry_ok;
  logic [IDX_W-1:0] arm_idx;
  logic [IDX_W-1:0] qry_idx;
  logic [IDX_W-1:0] sweep_idx;
  logic             rd_a_vld;
  logic [TS_W-1:0]  rd_a_ts;
  logic             rd_b_vld;
  logic [TS_W-1:0]  rd_b_ts;
  logic             live_a;
  logic             live_b;
  sweep_act_e       sweep_act;
  logic [TS_W-1:0]  sweep_age;

  always_comb begin
    now_ts    = cycle_cnt[TS_W-1:0];
    arm_ok    = arm_en && ({1'b0, arm_way} < WAY_LIM);
    qry_ok    = {1'b0, qry_way} < WAY_LIM;
    arm_idx   = IDX_W'(arm_set) * IDX_W'(DYN_WAYS) + IDX_W'(arm_way);
    qry_idx   = IDX_W'(qry_set) * IDX_W'(DYN_WAYS) + IDX_W'(qry_way);
    sweep_act = (rd_b_vld && !live_b) ? SWEEP_DROP : SWEEP_KEEP;
    sweep_age = now_ts - rd_b_ts;
  end

  rs_sweeper #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .ptr   (sweep_idx)
  );

  rs_store #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .TS_W    (TS_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (arm_ok),
    .wr_idx   (arm_idx),
    .wr_ts    (now_ts),
    .clr_en   (sweep_act == SWEEP_DROP),
    .clr_idx  (sweep_idx),
    .rd_a_idx (qry_idx),
    .rd_a_vld (rd_a_vld),
    .rd_a_ts  (rd_a_ts),
    .rd_b_idx (sweep_idx),
    .rd_b_vld (rd_b_vld),
    .rd_b_ts  (rd_b_ts)
  );

  rs_age_check #(
    .TS_W       (TS_W),
    .RET_CYCLES (RET_CYCLES)
  ) u_age_qry (
    .now_ts    (now_ts),
    .stamp     (rd_a_ts),
    .stamp_vld (rd_a_vld),
    .live      (live_a)
  );

  rs_age_check #(
    .TS_W       (TS_W),
    .RET_CYCLES (RET_CYCLES)
  ) u_age_sweep (
    .now_ts    (now_ts),
    .stamp     (rd_b_ts),
    .stamp_vld (rd_b_vld),
    .live      (live_b)
  );

  always_comb begin
    qry_alive = qry_en && qry_ok && live_a;
    qry_hit   = qry_alive && qry_tag_match;
  end

  // R2: a line armed last cycle answers alive now
  p_alive_after_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arm_ok) && qry_en && qry_ok && (qry_idx == $past(arm_idx)))
      |-> qry_alive);

  // R4: once a queried line reads dead it stays dead without a new arm
  p_dead_stays_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_en && qry_ok && !qry_alive && !(arm_ok && (arm_idx == qry_idx)))
      ##1 (qry_en && qry_ok && (qry_idx == $past(qry_idx)))
      |-> !qry_alive);

  // R6: no set sentry ever ages past window plus one sweep lap
  p_age_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_vld |-> (sweep_age <= AGE_BOUND));

endmodule

// File: tb/retention_sentry_tb.sv
module retention_sentry_tb;

  localparam int SETS  = 4;
  localparam int WAYS  = 3;
  localparam int RET   = 40;
  localparam int CNT_W = 32;
  localparam int SET_W = 2;
  localparam int WAY_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cycle_cnt;
  logic             arm_en;
  logic [SET_W-1:0] arm_set;
  logic [WAY_W-1:0] arm_way;
  logic             qry_en;
  logic [SET_W-1:0] qry_set;
  logic [WAY_W-1:0] qry_way;
  logic             qry_tag_match;
  logic             qry_alive;
  logic             qry_hit;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";
  bit    done   = 1'b0;

  // reference model in absolute cycles
  longint abs_cyc;
  bit     mv [SETS][WAYS];
  longint ma [SETS][WAYS];

  always #4 clk = ~clk;

  retention_sentry #(
    .SETS       (SETS),
    .DYN_WAYS   (WAYS),
    .RET_CYCLES (RET),
    .CNT_W      (CNT_W)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cycle_cnt     (cycle_cnt),
    .arm_en        (arm_en),
    .arm_set       (arm_set),
    .arm_way       (arm_way),
    .qry_en        (qry_en),
    .qry_set       (qry_set),
    .qry_way       (qry_way),
    .qry_tag_match (qry_tag_match),
    .qry_alive     (qry_alive),
    .qry_hit       (qry_hit)
  );

  initial begin
    abs_cyc   = 0;
    cycle_cnt = 32'hFFFF_FFE0;   // wraps inside the first live window (R5)
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mv[s][w] <= 1'b0;
    end else if (arm_en && (int'(arm_way) < WAYS)) begin
      mv[arm_set][arm_way] <= 1'b1;
      ma[arm_set][arm_way] <= abs_cyc;
    end
    abs_cyc   <= abs_cyc + 1;
    cycle_cnt <= cycle_cnt + 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      bit exp_alive;
      bit exp_hit;
      exp_alive = 1'b0;
      if (qry_en && (int'(qry_way) < WAYS))
        exp_alive = mv[qry_set][qry_way] &&
                    ((abs_cyc - ma[qry_set][qry_way]) < RET);
      exp_hit = exp_alive && qry_tag_match;
      checks++;
      if (qry_alive !== exp_alive) begin
        fails++;
        $display("FAIL %s alive set=%0d way=%0d actual=%0b expected=%0b",
                 phase, qry_set, qry_way, qry_alive, exp_alive);
      end
      checks++;
      if (qry_hit !== exp_hit) begin
        fails++;
        $display("FAIL %s hit set=%0d way=%0d actual=%0b expected=%0b",
                 phase, qry_set, qry_way, qry_hit, exp_hit);
      end
    end
  end

  task automatic drive(input bit ae, input int as_, input int aw_,
                       input bit qe, input int qs_, input int qw_,
                       input bit tm);
    @(posedge clk);
    #1;
    arm_en        = ae;
    arm_set       = SET_W'(as_);
    arm_way       = WAY_W'(aw_);
    qry_en        = qe;
    qry_set       = SET_W'(qs_);
    qry_way       = WAY_W'(qw_);
    qry_tag_match = tm;
  endtask

  task automatic probe(input int s, input int w, input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b1, s, w, 1'b1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    arm_en = 1'b0; arm_set = '0; arm_way = '0;
    qry_en = 1'b0; qry_set = '0; qry_way = '0; qry_tag_match = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: nothing alive after reset
    phase = "R1";
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) drive(1'b0, 0, 0, 1'b1, s, w, 1'b1);

    // R2 / R4 / R5: one arm, probe across the window edge and counter wrap
    phase = "R2";
    drive(1'b1, 1, 2, 1'b1, 1, 2, 1'b1);
    phase = "R5";
    probe(1, 2, 30);
    phase = "R4";
    probe(1, 2, 20);

    // R3: same-cycle arm and query sees the pre-arm state
    phase = "R3";
    drive(1'b1, 2, 0, 1'b1, 2, 0, 1'b1);
    probe(2, 0, 2);

    // R7: re-arm restarts the window
    phase = "R7";
    drive(1'b1, 0, 1, 1'b0, 0, 0, 1'b0);
    probe(0, 1, 30);
    drive(1'b1, 0, 1, 1'b1, 0, 1, 1'b1);
    probe(0, 1, 45);

    // R9: out-of-range way ignored
    phase = "R9";
    drive(1'b1, 3, 3, 1'b1, 3, 3, 1'b1);
    probe(3, 3, 3);

    // R10: other lines untouched by an arm
    phase = "R10";
    drive(1'b1, 3, 0, 1'b0, 0, 0, 1'b0);
    probe(3, 1, 2);
    probe(2, 0, 2);
    probe(3, 2, 2);
    probe(3, 0, 2);

    // R11: no query, no answer, even on a live line
    phase = "R11";
    drive(1'b1, 2, 2, 1'b0, 2, 2, 1'b1);
    for (int i = 0; i < 4; i++) drive(1'b0, 0, 0, 1'b0, 2, 2, 1'b1);

    // R8: tag mismatch on a live line, tag match on an expired line
    phase = "R8";
    for (int i = 0; i < 3; i++) drive(1'b0, 0, 0, 1'b1, 2, 2, 1'b0);
    probe(1, 2, 3);

    // R6: idle far past the 128-cycle timestamp range
    phase = "R6";
    drive(1'b1, 1, 1, 1'b0, 0, 0, 1'b0);
    probe(1, 1, 220);
    probe(0, 0, 2);

    drive(1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
    @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

endmodule